// File: doc/BRIEF.md
# Dual-Bank Planar Frame Memory Port

This block is the host-side access unit of a small frame store that holds eight planes. Each pixel is stored as one byte. The store is kept twice, in bank A and bank B. The host sees the memory in one of two views, chosen on each transaction by a view-select input:
- In the packed-pixel view, one address is one pixel byte.
- In the plane-slice view, one 16-bit word carries a single plane's bit for sixteen horizontally adjacent pixels.

A set of control inputs steers the banks:
- A read-select bit chooses the bank that host reads return.
- Two separate inhibit bits stop writes from reaching bank A or bank B.
- A display-select bit chooses the bank that feeds the scan-out read port.
- An eight-bit plane mask limits which planes any write may change.

The host interface accepts one transaction per cycle through a valid/ready pair, and read data comes back one cycle later. A separate scan-out port reads one pixel per cycle from the displayed bank, also with one cycle of latency. Video timing, raster operations and colour lookup live elsewhere.

Top module: `fb_bank_port`

## Requirements
- R1: While `rst_n` is low, `host_ready`, `rdata_valid`, `rdata` and `scan_pixel` are 0. `host_ready` is 1 from the first clock edge after reset release.
- R2: An accepted read (`host_valid` and `host_ready` high, `host_we` low) raises `rdata_valid` for exactly the next cycle, with the data. An accepted write does not raise `rdata_valid`.
- R3: With `host_view`=0 (packed), `host_addr` is the row-major pixel index. A read returns that pixel's byte in `rdata[7:0]`, with `rdata[15:8]`=0.
- R4: With `host_view`=1 (plane slice), `host_addr[GW+2:GW]` is the plane p and `host_addr[GW-1:0]` is the group g, where GW=log2(NPIX/16). The top address bit is ignored. Bit k of the word is bit p of pixel g*16+k.
- R5: A packed write changes only the stored bits whose planes have a set bit in `plane_mask`. Bit n of a pixel belongs to plane n.
- R6: A plane-slice write changes only bit p of the sixteen addressed pixels, and only when `plane_mask[p]` is set.
- R7: Host reads return bank B when `ctl_read_b`=1 and bank A when it is 0.
- R8: `ctl_nowr_a`=1 keeps bank A unchanged by writes, and `ctl_nowr_b`=1 keeps bank B unchanged. Each bit acts independently of the other.
- R9: A write with both inhibit bits clear updates both banks identically in the same cycle.
- R10: `scan_pixel` shows, one cycle after `scan_addr` is presented, the pixel from bank B when `ctl_display_b`=1 and from bank A otherwise.
- R11: A scan read and a host read in the same cycle as a host write to the same pixel return the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host transaction request |
| host_ready | output | 1 | Host transaction accepted this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_view | input | 1 | 0 = packed pixel, 1 = plane slice |
| host_addr | input | AW | Pixel index or plane-slice word address |
| host_wdata | input | 16 | Write data (bits 7:0 used in packed view) |
| plane_mask | input | 8 | Per-plane write enable |
| ctl_read_b | input | 1 | Host reads from bank B |
| ctl_display_b | input | 1 | Scan-out from bank B |
| ctl_nowr_a | input | 1 | Block writes to bank A |
| ctl_nowr_b | input | 1 | Block writes to bank B |
| rdata_valid | output | 1 | Read data present |
| rdata | output | 16 | Read data |
| scan_addr | input | AW | Scan-out pixel index |
| scan_pixel | output | 8 | Scan-out pixel |

## Verification
The bench aims at the edges where the two views meet. A plane-slice write with its plane masked off must leave memory intact, so a design that ignored the mask in that view would clear or set sixteen pixels. A write with exactly one bank inhibited must split the banks, so a design that shared a single write enable would leave both banks equal. A scan read or host read in the same cycle as a write to that pixel must return the old byte, so a design that bypassed write data would show the new value a cycle early. Random traffic across both views checks bit ordering within the word, where a reversed word or a wrong plane field would scramble reads.

// File: rtl/fb_bank_port.sv
module fb_bank_port #(
  parameter int NPIX = 256,
  localparam int AW = $clog2(NPIX),
  localparam int GW = AW - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_we,
  input  logic          host_view,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  input  logic [7:0]    plane_mask,
  input  logic          ctl_read_b,
  input  logic          ctl_display_b,
  input  logic          ctl_nowr_a,
  input  logic          ctl_nowr_b,
  output logic          rdata_valid,
  output logic [15:0]   rdata,
  input  logic [AW-1:0] scan_addr,
  output logic [7:0]    scan_pixel
);
  logic [7:0] mem [2][NPIX];

  wire [2:0]    pl  = host_addr[GW+2:GW];
  wire [GW-1:0] grp = host_addr[GW-1:0];
  wire          acc = host_valid && host_ready;
  wire [1:0]    wr_en = {~ctl_nowr_b, ~ctl_nowr_a} & {2{acc && host_we}};

  logic [15:0] slice;
  always_comb begin
    for (int k = 0; k < 16; k++)
      slice[k] = mem[ctl_read_b][{grp, 4'(k)}][pl];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (wr_en[b]) begin
        if (!host_view)
          mem[b][host_addr] <= (mem[b][host_addr] & ~plane_mask) | (host_wdata[7:0] & plane_mask);
        else if (plane_mask[pl])
          for (int k = 0; k < 16; k++)
            mem[b][{grp, 4'(k)}][pl] <= host_wdata[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ready  <= 1'b0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
      scan_pixel  <= '0;
    end else begin
      host_ready  <= 1'b1;
      rdata_valid <= acc && !host_we;
      if (acc && !host_we)
        rdata <= host_view ? slice : {8'h00, mem[ctl_read_b][host_addr]};
      scan_pixel <= mem[ctl_display_b][scan_addr];
    end
  end
endmodule

// File: rtl/fb_bank_port_chk.sv
module fb_bank_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic        host_we,
  input logic        host_view,
  input logic        rdata_valid,
  input logic [15:0] rdata
);
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> host_ready);

  assert_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=> rdata_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(host_valid && host_ready && !host_we));

  assert_packed_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_valid && !$past(host_view)) |-> (rdata[15:8] == 8'h00));
endmodule

bind fb_bank_port fb_bank_port_chk u_chk (.*);

// File: tb/sim_fb_bank_port.sv
module sim_fb_bank_port;
  localparam int NPIX = 256;
  localparam int AW = $clog2(NPIX);
  localparam int GW = AW - 4;
  localparam int GPP = NPIX / 16;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_we = 0, host_view = 0;
  logic host_ready, rdata_valid;
  logic [AW-1:0] host_addr = '0, scan_addr = '0;
  logic [15:0] host_wdata = '0, rdata;
  logic [7:0] plane_mask = '0, scan_pixel;
  logic ctl_read_b = 0, ctl_display_b = 0, ctl_nowr_a = 0, ctl_nowr_b = 0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] mb [2][NPIX];

  always #2 clk = ~clk;

  fb_bank_port #(.NPIX(NPIX)) u0 (.*);

  function automatic logic [15:0] exp_read(bit bank, bit view, int addr);
    logic [15:0] r;
    int p, g;
    if (!view) return {8'h00, mb[bank][addr]};
    p = (addr >> GW) & 7;
    g = addr & (GPP - 1);
    for (int k = 0; k < 16; k++) r[k] = mb[bank][g*16+k][p];
    return r;
  endfunction

  function automatic void model_write(bit view, int addr, logic [15:0] wd, logic [7:0] m, bit na, bit nb);
    int p, g;
    for (int b = 0; b < 2; b++) begin
      if ((b == 0 && na) || (b == 1 && nb)) continue;
      if (!view) begin
        for (int n = 0; n < 8; n++) if (m[n]) mb[b][addr][n] = wd[n];
      end else begin
        p = (addr >> GW) & 7;
        g = addr & (GPP - 1);
        if (m[p]) for (int k = 0; k < 16; k++) mb[b][g*16+k][p] = wd[k];
      end
    end
  endfunction

  task automatic check(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(bit v, bit we, bit view, int addr, logic [15:0] wd, logic [7:0] m,
                    bit rb, bit db, bit na, bit nb, int sa, string tag);
    bit erv;
    logic [15:0] erd;
    logic [7:0] esc;
    host_valid = v; host_we = we; host_view = view; host_addr = AW'(addr);
    host_wdata = wd; plane_mask = m; ctl_read_b = rb; ctl_display_b = db;
    ctl_nowr_a = na; ctl_nowr_b = nb; scan_addr = AW'(sa);
    erv = v && !we;
    erd = exp_read(rb, view, addr);
    esc = mb[db][sa];
    @(posedge clk); #1;
    check(rdata_valid == erv, tag, "rdata_valid", 16'(rdata_valid), 16'(erv));
    if (erv) check(rdata == erd, tag, "rdata", rdata, erd);
    check(scan_pixel == esc, tag, "scan_pixel", 16'(scan_pixel), 16'(esc));
    if (v && we) model_write(view, addr, wd, m, na, nb);
  endtask

  task automatic rd(bit bank, bit view, int addr, string tag);
    op(1, 0, view, addr, 16'h0, 8'h00, bank, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    check(host_ready == 0 && rdata_valid == 0 && rdata == 0 && scan_pixel == 0, "R1",
          "reset outputs", {host_ready, rdata_valid, rdata[7:0], scan_pixel[5:0]}, 16'h0);
    rst_n = 1;
    @(posedge clk); #1;
    check(host_ready == 1, "R1", "host_ready", 16'(host_ready), 16'h1);

    for (int i = 0; i < NPIX; i++) op(1, 1, 0, i, 16'(i*37+5), 8'hFF, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 8; i++) begin
      rd(0, 0, i*31, "R3");
      rd(1, 0, i*31, "R9");
    end

    op(1, 1, 0, 10, 16'h00A5, 8'hFF, 0, 0, 0, 0, 0, "R9");
    rd(0, 0, 10, "R9");
    rd(1, 0, 10, "R9");

    op(1, 1, 0, 11, 16'h003C, 8'hFF, 0, 0, 0, 1, 0, "R8");
    rd(0, 0, 11, "R8");
    rd(1, 0, 11, "R7");
    op(1, 1, 0, 11, 16'h00C3, 8'hFF, 0, 0, 1, 0, 0, "R8");
    rd(0, 0, 11, "R8");
    rd(1, 0, 11, "R8");
    op(1, 1, 1, 5, 16'hFFFF, 8'hFF, 0, 0, 1, 1, 0, "R8");
    rd(0, 1, 5, "R8");
    rd(1, 1, 5, "R8");

    op(1, 1, 0, 12, 16'h00FF, 8'h0F, 0, 0, 0, 0, 0, "R5");
    rd(0, 0, 12, "R5");
    op(1, 1, 0, 13, 16'h0000, 8'h00, 0, 0, 0, 0, 0, "R5");
    rd(1, 0, 13, "R5");

    op(1, 1, 1, 3*GPP + 1, 16'hFFFF, 8'h08, 0, 0, 0, 0, 0, "R6");
    for (int k = 14; k < 34; k++) rd(0, 0, k, "R6");
    op(1, 1, 1, 3*GPP + 1, 16'h0000, 8'hF7, 0, 0, 0, 0, 0, "R6");
    rd(0, 1, 3*GPP + 1, "R6");
    op(1, 1, 1, 6*GPP + 2, 16'h8001, 8'h40, 0, 0, 0, 0, 0, "R4");
    rd(1, 1, 6*GPP + 2, "R4");
    rd(0, 0, 32, "R4");
    rd(0, 0, 47, "R4");

    op(1, 1, 0, 20, 16'h0011, 8'hFF, 0, 0, 1, 0, 0, "R10");
    op(0, 0, 0, 0, 16'h0, 8'h0, 0, 1, 0, 0, 20, "R10");
    op(0, 0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, 20, "R10");

    op(1, 1, 0, 40, 16'h0077, 8'hFF, 0, 0, 0, 0, 40, "R11");
    op(0, 0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, 40, "R11");
    op(1, 1, 0, 41, 16'h0066, 8'hFF, 0, 1, 0, 0, 41, "R11");

    for (int i = 0; i < 4000; i++) begin
      bit v, we, view;
      v = ($urandom % 4) != 0;
      we = $urandom % 2;
      view = $urandom % 2;
      op(v, we, view, $urandom % NPIX, 16'($urandom), 8'($urandom),
         $urandom % 2, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0,
         $urandom % NPIX, view ? "R4" : "R3");
    end
    op(0, 0, 0, 0, 16'h0, 8'h0, 0, 0, 0, 0, 0, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule